// File: doc/BRIEF.md
# Full-Map Directory Sharer Tracker

This block is one slice of a coherence directory that records, for every tracked line, which caches hold a copy. The record is one bit per cache. When a read, exclusive or invalidate-all request arrives for a line, the block reads that line's bit vector. In the same cycle it answers with three things: the caches that must be probed, how much acknowledgement credit the memory response is worth, and whether the requestor may take the line in exclusive state. Probes go only to the caches that actually hold the line. The caches that are skipped are reported as a silent-ack count, so the requestor can still close its own ack tally.

Unblock and writeback messages from caches change the vector on the next clock edge. So do exclusive requests and allocate or deallocate commands from the surrounding directory. A protocol-error output flags message combinations that a correct system never produces. The flag does not stop any update from being applied.

Top module: `sharer_tracker`

## Requirements
- R1: After reset no line is allocated. A request to an unallocated line behaves as if the line had no sharers.
- R2: For a read (reqKind 0, and also code 3) or an exclusive request (reqKind 1), the forward set is the line's vector with the requestor's bit cleared. fwdValid is high exactly when that set is non-empty, and fwdMask equals the set. With no request, fwdValid, fwdMask and exclGrant are all zero.
- R3: When the forward set is non-empty, ackWeight is 1 and silentAcks is NUM_CACHES minus the popcount of the forward set minus 1. When it is empty, ackWeight is NUM_CACHES and silentAcks is 0.
- R4: exclGrant is high for a read or exclusive request exactly when the forward set is empty.
- R5: An exclusive request to an allocated line leaves that line's vector holding only the requestor from the next cycle on.
- R6: A shared unblock (updKind 0) adds the sender to the vector. A modified unblock (updKind 1) replaces the vector with the sender alone and records the sender as owner.
- R7: A dirty writeback (updKind 2) and a clean writeback (updKind 3) both remove the sender from the vector.
- R8: An invalidate-all (reqKind 2) puts the whole vector on fwdMask and raises fwdValid when that vector is non-empty. For any request, pendingCount is the popcount of the line's vector.
- R9: protoErr is high in the cycle of any of these: a read from a cache already in the vector; an invalidate-all on an empty vector; a writeback from a sender not in the vector; a shared unblock from the recorded owner of an allocated line.
- R10: Allocate (mgmtValid with mgmtAlloc=1) marks the line valid, with an empty vector and owner mgmtId. Deallocate (mgmtAlloc=0) makes the line unallocated. Updates and exclusive requests aimed at an unallocated line change nothing.
- R11: At most one line changes per cycle. An allocate or deallocate wins over an effective update, and an effective update wins over an exclusive request. The losing action is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 read, 1 exclusive, 2 invalidate-all, 3 read |
| reqId | input | ID_W | Requesting cache |
| reqLine | input | LINE_W | Line the request targets |
| updValid | input | 1 | Unblock or writeback present |
| updKind | input | 2 | 0 shared unblock, 1 modified unblock, 2 dirty writeback, 3 clean writeback |
| updId | input | ID_W | Sending cache |
| updLine | input | LINE_W | Line the message targets |
| mgmtValid | input | 1 | Allocate or deallocate command |
| mgmtAlloc | input | 1 | 1 allocate, 0 deallocate |
| mgmtLine | input | LINE_W | Line to allocate or drop |
| mgmtId | input | ID_W | Initial owner on allocate |
| fwdValid | output | 1 | A probe must be sent |
| fwdMask | output | NUM_CACHES | Caches to probe |
| ackWeight | output | CNT_W | Ack credit carried by the response |
| silentAcks | output | CNT_W | Caches skipped by the multicast |
| exclGrant | output | 1 | Respond with exclusive data |
| pendingCount | output | CNT_W | Popcount of the line's vector |
| protoErr | output | 1 | Protocol violation seen this cycle |

## Verification
On every cycle the checker tests the relationships inside one response. The requestor never appears in its own forward mask. The ack weight plus the silent acks plus the probed caches always account for every cache, and exclusive grant is exactly the absence of a forward. For an invalidate-all, the pending count matches the multicast. The checker also confirms that an exclusive request leaves its requestor alone on the line. The actual contents of the vectors over time are shown only by the bench's reference model. These include the ordering of unblocks and writebacks, the error cases, allocation and the priority between simultaneous actions.

// File: rtl/sharer_pkg.sv
`timescale 1ns/1ps
package sharer_pkg;

  typedef enum logic [1:0] {
    REQ_READ   = 2'd0,
    REQ_EXCL   = 2'd1,
    REQ_INVALL = 2'd2,
    REQ_READ2  = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    UPD_SH_UNBLK  = 2'd0,
    UPD_MOD_UNBLK = 2'd1,
    UPD_WB_DIRTY  = 2'd2,
    UPD_WB_CLEAN  = 2'd3
  } updKind_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ALLOC,
    OP_DEALLOC,
    OP_SOLO,
    OP_ADD,
    OP_REMOVE,
    OP_OWN
  } wrOp_e;

  typedef enum logic [1:0] {
    SRC_REQ,
    SRC_UPD,
    SRC_MGMT
  } wrSrc_e;

  typedef struct packed {
    wrOp_e  op;
    wrSrc_e src;
  } ctrlStrobe_t;

endpackage

// File: rtl/sharer_popcnt.sv
`timescale 1ns/1ps
module sharer_popcnt #(
  parameter int W  = 4,
  parameter int CW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/sharer_ctrl.sv
`timescale 1ns/1ps
module sharer_ctrl
  import sharer_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic [ID_W-1:0] reqId,
  input  logic            reqHit,
  input  logic            reqEmpty,
  input  logic            reqLineVld,
  input  logic            updValid,
  input  logic [1:0]      updKind,
  input  logic [ID_W-1:0] updId,
  input  logic            updLineVld,
  input  logic [ID_W-1:0] updOwner,
  input  logic            updMember,
  input  logic            mgmtValid,
  input  logic            mgmtAlloc,
  output ctrlStrobe_t     strobe,
  output logic            protoErr
);

  logic isInvall, isExcl, isRead;
  logic isWb, isShUnblk;

  assign isInvall  = (reqKind == REQ_INVALL);
  assign isExcl    = (reqKind == REQ_EXCL);
  assign isRead    = !isInvall && !isExcl;
  assign isWb      = (updKind == UPD_WB_DIRTY) || (updKind == UPD_WB_CLEAN);
  assign isShUnblk = (updKind == UPD_SH_UNBLK);

  // single write per cycle: mgmt, then effective update, then exclusive request
  always_comb begin
    strobe.op  = OP_NONE;
    strobe.src = SRC_REQ;
    if (mgmtValid) begin
      strobe.op  = mgmtAlloc ? OP_ALLOC : OP_DEALLOC;
      strobe.src = SRC_MGMT;
    end else if (updValid && updLineVld) begin
      strobe.src = SRC_UPD;
      unique case (updKind)
        UPD_SH_UNBLK:  strobe.op = OP_ADD;
        UPD_MOD_UNBLK: strobe.op = OP_OWN;
        default:       strobe.op = OP_REMOVE;
      endcase
    end else if (reqValid && isExcl && reqLineVld) begin
      strobe.op  = OP_SOLO;
      strobe.src = SRC_REQ;
    end
  end

  logic errRead, errInv, errUnblk, errWb;

  assign errRead  = reqValid && isRead && reqHit;
  assign errInv   = reqValid && isInvall && reqEmpty;
  assign errUnblk = updValid && updLineVld && isShUnblk && (updOwner == updId);
  assign errWb    = updValid && updLineVld && isWb && !updMember;

  assign protoErr = errRead || errInv || errUnblk || errWb;

endmodule

// File: rtl/sharer_datapath.sv
`timescale 1ns/1ps
module sharer_datapath
  import sharer_pkg::*;
#(
  parameter int N      = 4,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int LINE_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqId,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [ID_W-1:0]   updId,
  input  logic [LINE_W-1:0] updLine,
  input  logic [LINE_W-1:0] mgmtLine,
  input  logic [ID_W-1:0]   mgmtId,
  output logic              reqHit,
  output logic              reqEmpty,
  output logic              reqLineVld,
  output logic              updLineVld,
  output logic [ID_W-1:0]   updOwner,
  output logic              updMember,
  output logic              fwdValid,
  output logic [N-1:0]      fwdMask,
  output logic [CNT_W-1:0]  ackWeight,
  output logic [CNT_W-1:0]  silentAcks,
  output logic              exclGrant,
  output logic [CNT_W-1:0]  pendingCount
);

  localparam logic          MULTI    = (N > 1);
  localparam logic [N-1:0]  ONE_BIT  = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]    vecMem [LINES];
  logic [ID_W-1:0] ownMem [LINES];
  logic [LINES-1:0] vldMem;

  // ---------------- write side ----------------
  logic [LINE_W-1:0] wrLine;
  logic [ID_W-1:0]   wrId;
  logic [N-1:0]      wrOh;

  always_comb begin
    unique case (strobe.src)
      SRC_UPD:  begin wrLine = updLine;  wrId = updId;  end
      SRC_MGMT: begin wrLine = mgmtLine; wrId = mgmtId; end
      default:  begin wrLine = reqLine;  wrId = reqId;  end
    endcase
  end

  assign wrOh = ONE_BIT << wrId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldMem <= '0;
      for (int g = 0; g < LINES; g++) begin
        vecMem[g] <= '0;
        ownMem[g] <= '0;
      end
    end else if (strobe.op != OP_NONE) begin
      for (int g = 0; g < LINES; g++) begin
        if (wrLine == LINE_W'(g)) begin
          unique case (strobe.op)
            OP_ALLOC: begin
              vldMem[g] <= 1'b1;
              vecMem[g] <= '0;
              ownMem[g] <= wrId;
            end
            OP_DEALLOC: begin
              vldMem[g] <= 1'b0;
              vecMem[g] <= '0;
            end
            OP_SOLO:   vecMem[g] <= wrOh;
            OP_ADD:    vecMem[g] <= vecMem[g] | wrOh;
            OP_REMOVE: vecMem[g] <= vecMem[g] & ~wrOh;
            OP_OWN: begin
              vecMem[g] <= wrOh;
              ownMem[g] <= wrId;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- read side ----------------
  logic [N-1:0] reqVec, reqOh, fwdSet;
  logic [CNT_W-1:0] popVec, popFwd;

  assign reqLineVld = vldMem[reqLine];
  assign reqVec     = reqLineVld ? vecMem[reqLine] : '0;
  assign reqOh      = ONE_BIT << reqId;
  assign fwdSet     = reqVec & ~reqOh;

  sharer_popcnt #(.W(N), .CW(CNT_W)) u_popVec (.vec(reqVec), .cnt(popVec));
  sharer_popcnt #(.W(N), .CW(CNT_W)) u_popFwd (.vec(fwdSet), .cnt(popFwd));

  assign reqHit     = |(reqVec & reqOh);
  assign reqEmpty   = (popVec == '0);
  assign updLineVld = vldMem[updLine];
  assign updOwner   = ownMem[updLine];
  assign updMember  = |(vecMem[updLine] & (ONE_BIT << updId));

  always_comb begin
    fwdValid     = 1'b0;
    fwdMask      = '0;
    ackWeight    = '0;
    silentAcks   = '0;
    exclGrant    = 1'b0;
    pendingCount = '0;
    if (reqValid) begin
      pendingCount = popVec;
      if (reqKind == REQ_INVALL) begin
        fwdMask  = reqVec;
        fwdValid = MULTI && (popVec != '0);
      end else if (popFwd != '0) begin
        fwdValid   = MULTI;
        fwdMask    = fwdSet;
        ackWeight  = CNT_W'(1);
        silentAcks = CNT_W'(N - 1) - popFwd;
      end else begin
        ackWeight = CNT_W'(N);
        exclGrant = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sharer_tracker.sv
`timescale 1ns/1ps
module sharer_tracker
  import sharer_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_LINES  = 8,
  localparam int ID_W   = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W  = $clog2(NUM_CACHES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqId,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              updValid,
  input  logic [1:0]        updKind,
  input  logic [ID_W-1:0]   updId,
  input  logic [LINE_W-1:0] updLine,
  input  logic              mgmtValid,
  input  logic              mgmtAlloc,
  input  logic [LINE_W-1:0] mgmtLine,
  input  logic [ID_W-1:0]   mgmtId,
  output logic              fwdValid,
  output logic [NUM_CACHES-1:0] fwdMask,
  output logic [CNT_W-1:0]  ackWeight,
  output logic [CNT_W-1:0]  silentAcks,
  output logic              exclGrant,
  output logic [CNT_W-1:0]  pendingCount,
  output logic              protoErr
);

  ctrlStrobe_t     strobe;
  logic            reqHit, reqEmpty, reqLineVld;
  logic            updLineVld, updMember;
  logic [ID_W-1:0] updOwner;

  sharer_ctrl #(.ID_W(ID_W)) u_ctrl (
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .reqId     (reqId),
    .reqHit    (reqHit),
    .reqEmpty  (reqEmpty),
    .reqLineVld(reqLineVld),
    .updValid  (updValid),
    .updKind   (updKind),
    .updId     (updId),
    .updLineVld(updLineVld),
    .updOwner  (updOwner),
    .updMember (updMember),
    .mgmtValid (mgmtValid),
    .mgmtAlloc (mgmtAlloc),
    .strobe    (strobe),
    .protoErr  (protoErr)
  );

  sharer_datapath #(
    .N(NUM_CACHES), .LINES(NUM_LINES), .ID_W(ID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .reqId       (reqId),
    .reqLine     (reqLine),
    .updId       (updId),
    .updLine     (updLine),
    .mgmtLine    (mgmtLine),
    .mgmtId      (mgmtId),
    .reqHit      (reqHit),
    .reqEmpty    (reqEmpty),
    .reqLineVld  (reqLineVld),
    .updLineVld  (updLineVld),
    .updOwner    (updOwner),
    .updMember   (updMember),
    .fwdValid    (fwdValid),
    .fwdMask     (fwdMask),
    .ackWeight   (ackWeight),
    .silentAcks  (silentAcks),
    .exclGrant   (exclGrant),
    .pendingCount(pendingCount)
  );

endmodule

// File: rtl/sharer_tracker_chk.sv
`timescale 1ns/1ps
module sharer_tracker_chk #(
  parameter int NUM_CACHES = 4,
  parameter int ID_W   = 2,
  parameter int LINE_W = 3,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ID_W-1:0]   reqId,
  input logic [LINE_W-1:0] reqLine,
  input logic              updValid,
  input logic              mgmtValid,
  input logic              fwdValid,
  input logic [NUM_CACHES-1:0] fwdMask,
  input logic [CNT_W-1:0]  ackWeight,
  input logic [CNT_W-1:0]  silentAcks,
  input logic              exclGrant,
  input logic [CNT_W-1:0]  pendingCount,
  input logic              protoErr
);

  p_req_not_probed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd2) |-> !fwdMask[reqId]);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!fwdValid && fwdMask == '0 && !exclGrant));

  p_ack_split_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd2 && fwdValid) |->
      (ackWeight == CNT_W'(1) &&
       (int'(silentAcks) + $countones(fwdMask) == NUM_CACHES - 1)));

  p_ack_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd2 && !fwdValid) |->
      (ackWeight == CNT_W'(NUM_CACHES) && silentAcks == '0));

  p_excl_no_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd2) |-> (exclGrant != fwdValid));

  // R5: requestor alone after its own exclusive request (nothing else written)
  p_solo_after_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0 &&
     $past(reqValid && reqKind == 2'd1 && !updValid && !mgmtValid) &&
     reqLine == $past(reqLine) && reqId == $past(reqId)) |-> !fwdValid);

  p_inv_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2) |-> ($countones(fwdMask) == int'(pendingCount)));

  p_inv_empty_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2 && pendingCount == '0) |-> protoErr);

endmodule

bind sharer_tracker sharer_tracker_chk #(
  .NUM_CACHES(NUM_CACHES), .ID_W(ID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqId(reqId),
  .reqLine(reqLine), .updValid(updValid), .mgmtValid(mgmtValid),
  .fwdValid(fwdValid), .fwdMask(fwdMask), .ackWeight(ackWeight),
  .silentAcks(silentAcks), .exclGrant(exclGrant), .pendingCount(pendingCount),
  .protoErr(protoErr)
);

// File: tb/sim_sharer_tracker.sv
`timescale 1ns/1ps
module sim_sharer_tracker;
  localparam int N = 4;
  localparam int L = 8;
  localparam int ID_W = 2;
  localparam int LINE_W = 3;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, updValid = 0, mgmtValid = 0, mgmtAlloc = 0;
  logic [1:0] reqKind = 0, updKind = 0;
  logic [ID_W-1:0] reqId = 0, updId = 0, mgmtId = 0;
  logic [LINE_W-1:0] reqLine = 0, updLine = 0, mgmtLine = 0;
  logic fwdValid, exclGrant, protoErr;
  logic [N-1:0] fwdMask;
  logic [CNT_W-1:0] ackWeight, silentAcks, pendingCount;

  always #10 clk = ~clk;

  sharer_tracker #(.NUM_CACHES(N), .NUM_LINES(L)) u0 (.*);

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int refVec [L];
  int refOwn [L];
  bit refVld [L];

  function automatic int pop(input int v);
    int c = 0;
    for (int i = 0; i < N; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input bit rv, input int rk, input int rid, input int rl,
                       input bit uv, input int uk, input int uid, input int ul,
                       input bit mv, input bit ma, input int ml, input int mid);
    int effv, fwd, pf, pv;
    int eFv, eMask, eAck, eSil, eEx, ePend, eErr;
    @(negedge clk);
    reqValid = rv; reqKind = 2'(rk); reqId = ID_W'(rid); reqLine = LINE_W'(rl);
    updValid = uv; updKind = 2'(uk); updId = ID_W'(uid); updLine = LINE_W'(ul);
    mgmtValid = mv; mgmtAlloc = ma; mgmtLine = LINE_W'(ml); mgmtId = ID_W'(mid);
    #2;
    effv = refVld[rl] ? refVec[rl] : 0;
    fwd = effv & ~(1 << rid);
    pf = pop(fwd); pv = pop(effv);
    eFv = 0; eMask = 0; eAck = 0; eSil = 0; eEx = 0; ePend = 0;
    if (rv) begin
      ePend = pv;
      if (rk == 2) begin eMask = effv; eFv = (pv != 0); end
      else if (pf > 0) begin eFv = 1; eMask = fwd; eAck = 1; eSil = N - pf - 1; end
      else begin eAck = N; eEx = 1; end
    end
    eErr = 0;
    if (rv && rk != 1 && rk != 2 && ((effv >> rid) & 1)) eErr = 1;
    if (rv && rk == 2 && pv == 0) eErr = 1;
    if (uv && refVld[ul] && uk == 0 && refOwn[ul] == uid) eErr = 1;
    if (uv && refVld[ul] && uk >= 2 && !((refVec[ul] >> uid) & 1)) eErr = 1;
    chk("R2 fwdValid", int'(fwdValid), eFv);
    chk("R2/R8 fwdMask", int'(fwdMask), eMask);
    chk("R3 ackWeight", int'(ackWeight), eAck);
    chk("R3 silentAcks", int'(silentAcks), eSil);
    chk("R4 exclGrant", int'(exclGrant), eEx);
    chk("R8 pendingCount", int'(pendingCount), ePend);
    chk("R9 protoErr", int'(protoErr), eErr);
    // next-state per R5/R6/R7/R10/R11
    if (mv) begin
      if (ma) begin refVld[ml] = 1; refVec[ml] = 0; refOwn[ml] = mid; end
      else begin refVld[ml] = 0; refVec[ml] = 0; end
    end else if (uv && refVld[ul]) begin
      if (uk == 0) refVec[ul] |= (1 << uid);
      else if (uk == 1) begin refVec[ul] = 1 << uid; refOwn[ul] = uid; end
      else refVec[ul] &= ~(1 << uid);
    end else if (rv && rk == 1 && refVld[rl]) begin
      refVec[rl] = 1 << rid;
    end
  endtask

  task automatic rd(input int kind, input int id, input int line);
    apply(1, kind, id, line, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic up(input int kind, input int id, input int line);
    apply(0, 0, 0, 0, 1, kind, id, line, 0, 0, 0, 0);
  endtask
  task automatic mg(input bit alloc, input int line, input int id);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1, alloc, line, id);
  endtask

  initial begin
    for (int i = 0; i < L; i++) begin refVec[i] = 0; refOwn[i] = 0; refVld[i] = 0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: idle after reset, then a request to an untouched line
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(0, 2, 5);
    // R10: allocate line 0 with owner 1
    mg(1, 0, 1);
    // R5: exclusive request by cache 1
    rd(1, 1, 0);
    rd(0, 1, 0);
    // R6: shared unblocks from 2 and 3, then a read by 0 probes {1,2,3}
    up(0, 2, 0);
    up(0, 3, 0);
    rd(0, 0, 0);
    // R9: read by an existing sharer, shared unblock from owner 1
    rd(0, 2, 0);
    up(0, 1, 0);
    // R7: clean writeback from 2, dirty writeback from non-member 0 (R9)
    up(3, 2, 0);
    up(2, 0, 0);
    // R6: modified unblock from 3; read by 0 probes only 3
    up(1, 3, 0);
    rd(0, 0, 0);
    // R8: invalidate-all on line 0 and on an empty allocated line
    rd(2, 0, 0);
    mg(1, 4, 0);
    rd(2, 1, 4);
    // R10: deallocate, then updates and exclusive requests are ignored
    mg(0, 0, 0);
    up(0, 1, 0);
    rd(1, 2, 0);
    rd(0, 3, 0);
    // R11: allocate and shared unblock on the same line in one cycle
    apply(0, 0, 0, 0, 1, 0, 2, 1, 1, 1, 1, 0);
    rd(0, 0, 1);
    // R11: update beats exclusive request
    apply(1, 1, 3, 4, 1, 0, 2, 4, 0, 0, 0, 0);
    rd(0, 0, 4);
    // mixed traffic over four lines
    for (int k = 0; k < 4000; k++) begin
      bit rv, uv, mv;
      rv = ($urandom % 4) != 0;
      uv = ($urandom % 3) == 0;
      mv = ($urandom % 25) == 0;
      apply(rv, $urandom % 4, $urandom % N, $urandom % 4,
            uv, $urandom % 4, $urandom % N, $urandom % 4,
            mv, ($urandom % 4) != 0, $urandom % 4, $urandom % N);
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule